// File: doc/BRIEF.md
# Microcoded Two-Register Byte Processor

A very small processor core holding two 8-bit data registers, X and T, plus a carry flag and a sign flag. It reads opcodes and immediate bytes from a byte-wide read-only program store over a 24-bit address bus. Every instruction starts with a fetch microstep that captures the opcode and advances the program counter. The following microsteps come from a microcode table indexed by instruction class and step number. Each microstep drives register load enables, the ALU function, and the program-counter increment or jump load.

The instruction set is minimal: do nothing, load X from an immediate byte, exchange X and T, clear carry, add T and carry into X, two conditional absolute jumps on the sign flag, and stop. The exchange uses three XOR microsteps because there is no spare register. A jump overwrites only the low byte of the program counter. The program store is assumed to answer combinationally: `rd_data` must carry the byte at `mem_addr` within the same cycle. It never stalls, so the bus carries no valid/ready handshake and applies no back-pressure.

Top module: `bytecore_top`

## Requirements
- R1: While reset is low and after it is released, the address output is 0, X reads 0, the opcode output reads 0x00, the halted flag is 0, and T, carry and sign are 0.
- R2: In every fetch microstep the byte on the read bus is latched as the opcode and the address advances by one, so code without taken jumps runs from consecutive addresses.
- R3: Opcodes are 0x00 no-op, 0x01 load X immediate, 0x02 exchange, 0x03 clear carry, 0x04 add, 0x05 jump if minus, 0x06 jump if plus, 0xFF halt. Any other value behaves as a no-op of one byte.
- R4: Load X immediate copies the byte that follows the opcode into X, and execution resumes two bytes past the opcode.
- R5: Exchange swaps X and T in three XOR microsteps (X^=T, T^=X, X^=T).
- R6: Add writes the low 8 bits of X+T+carry to X, sets carry to the carry-out, and sets sign to bit 7 of the result. No other instruction changes the sign flag.
- R7: Clear carry sets the carry flag to 0, so a following add does not include the carry left by an earlier add.
- R8: Jump-if-minus is taken when sign is 1 and jump-if-plus when sign is 0. An untaken jump skips its target byte and continues at the next instruction.
- R9: A taken jump replaces only address bits 7:0 with the target byte. Bits 23:8 keep their value.
- R10: After 0xFF executes, the halted flag goes to 1, and the address, X and the opcode output stay unchanged until reset.
- R11: The Fibonacci loop (load 1, exchange, load 0, then clear carry, add, jump-if-minus out, exchange, jump-if-plus back) halts with X = 144.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 24 | Program store address (program counter) |
| rd_data | input | 8 | Byte read from the program store at mem_addr |
| halted | output | 1 | High once the halt opcode has executed |
| dbg_op | output | 8 | Opcode currently latched |
| dbg_x | output | 8 | Current value of register X |

## Verification
The hardest property to observe is R9. The high address byte only becomes nonzero after execution runs sequentially past address 0xFF. The stimulus therefore jumps to 0xFE and lets two no-ops carry the counter into 0x100, where a second jump must land at 0x110 and not at 0x010. Carry and sign cannot be read at the ports. Sign is exposed through the address at which the program halts after a jump-if-minus, and carry through the value of a second add into a cleared X.

// File: rtl/bytecore_pkg.sv
package bytecore_pkg;
  localparam int DATA_W = 8;
  localparam int STEP_W = 2;

  localparam logic [DATA_W-1:0] OP_NOP = 8'h00;
  localparam logic [DATA_W-1:0] OP_LDX = 8'h01;
  localparam logic [DATA_W-1:0] OP_SXT = 8'h02;
  localparam logic [DATA_W-1:0] OP_CLC = 8'h03;
  localparam logic [DATA_W-1:0] OP_AXT = 8'h04;
  localparam logic [DATA_W-1:0] OP_JMI = 8'h05;
  localparam logic [DATA_W-1:0] OP_JPL = 8'h06;
  localparam logic [DATA_W-1:0] OP_HLT = 8'hFF;

  typedef enum logic [1:0] {XS_KEEP, XS_IMM, XS_XOR, XS_ADD} xsel_e;
  typedef enum logic [2:0] {K_NOP, K_LDX, K_SXT, K_CLC, K_AXT, K_JMI, K_JPL, K_HLT} kind_e;

  typedef struct packed {
    xsel_e xsel;
    logic  t_xor;
    logic  clr_c;
    logic  pc_inc;
    logic  jmp;
    logic  jmp_neg;
    logic  halt;
    logic  last;
  } uop_t;

  function automatic kind_e classify(input logic [DATA_W-1:0] op);
    case (op)
      OP_LDX:  return K_LDX;
      OP_SXT:  return K_SXT;
      OP_CLC:  return K_CLC;
      OP_AXT:  return K_AXT;
      OP_JMI:  return K_JMI;
      OP_JPL:  return K_JPL;
      OP_HLT:  return K_HLT;
      default: return K_NOP;
    endcase
  endfunction
endpackage

// File: rtl/bytecore_ucode.sv
module bytecore_ucode
  import bytecore_pkg::*;
(
  input  kind_e             kind,
  input  logic [STEP_W-1:0] step,
  output uop_t              uop
);
  always_comb begin
    uop = '{xsel: XS_KEEP, t_xor: 1'b0, clr_c: 1'b0, pc_inc: 1'b0,
            jmp: 1'b0, jmp_neg: 1'b0, halt: 1'b0, last: 1'b1};
    case (kind)
      K_LDX: begin
        uop.xsel   = XS_IMM;
        uop.pc_inc = 1'b1;
      end
      K_SXT: begin
        case (step)
          2'd1:    begin uop.xsel = XS_XOR; uop.last = 1'b0; end
          2'd2:    begin uop.t_xor = 1'b1;  uop.last = 1'b0; end
          default: uop.xsel = XS_XOR;
        endcase
      end
      K_CLC: uop.clr_c = 1'b1;
      K_AXT: uop.xsel = XS_ADD;
      K_JMI: begin uop.jmp = 1'b1; uop.jmp_neg = 1'b1; end
      K_JPL: uop.jmp = 1'b1;
      K_HLT: uop.halt = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/bytecore_regs.sv
module bytecore_regs
  import bytecore_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  uop_t              uop,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] t_q,
  output logic              c_q,
  output logic              n_q
);
  logic [DATA_W:0] sum;
  assign sum = {1'b0, x_q} + {1'b0, t_q} + {{DATA_W{1'b0}}, c_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      t_q <= '0;
      c_q <= 1'b0;
      n_q <= 1'b0;
    end else if (en) begin
      case (uop.xsel)
        XS_IMM:  x_q <= imm;
        XS_XOR:  x_q <= x_q ^ t_q;
        XS_ADD:  begin
          x_q <= sum[DATA_W-1:0];
          c_q <= sum[DATA_W];
          n_q <= sum[DATA_W-1];
        end
        default: ;
      endcase
      if (uop.t_xor) t_q <= t_q ^ x_q;
      if (uop.clr_c) c_q <= 1'b0;
    end
  end

  AST_SIGN_ONLY_BY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && uop.xsel == XS_ADD) |=> $stable(n_q)); // R6
  AST_CLC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && uop.clr_c) |=> !c_q); // R7
endmodule

// File: rtl/bytecore_pc.sv
module bytecore_pc #(
  parameter int ADDR_W = 24,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              load_lo,
  input  logic [LO_W-1:0]   lo_val,
  output logic [ADDR_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (load_lo) pc_q[LO_W-1:0] <= lo_val;
    else if (inc)     pc_q <= pc_q + 1'b1;
  end

  AST_JUMP_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo |=> pc_q[ADDR_W-1:LO_W] == $past(pc_q[ADDR_W-1:LO_W])); // R9
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo |=> pc_q[LO_W-1:0] == $past(lo_val)); // R9
endmodule

// File: rtl/bytecore_top.sv
module bytecore_top
  import bytecore_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              halted,
  output logic [DATA_W-1:0] dbg_op,
  output logic [DATA_W-1:0] dbg_x
);
  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] op_q;
  logic              halt_q;
  logic              fetch, exec, take;
  uop_t              uop;
  logic [DATA_W-1:0] x_q, t_q;
  logic              c_q, n_q;

  assign fetch = !halt_q && (step_q == '0);
  assign exec  = !halt_q && (step_q != '0);

  bytecore_ucode u_ucode (
    .kind (classify(op_q)),
    .step (step_q),
    .uop  (uop)
  );

  assign take = uop.jmp && (uop.jmp_neg ? n_q : !n_q);

  bytecore_pc #(.ADDR_W(ADDR_W), .LO_W(DATA_W)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (fetch || (exec && (uop.pc_inc || (uop.jmp && !take)))),
    .load_lo (exec && take),
    .lo_val  (rd_data),
    .pc_q    (mem_addr)
  );

  bytecore_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (exec),
    .uop   (uop),
    .imm   (rd_data),
    .x_q   (x_q),
    .t_q   (t_q),
    .c_q   (c_q),
    .n_q   (n_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      op_q   <= '0;
      halt_q <= 1'b0;
    end else if (fetch) begin
      op_q   <= rd_data;
      step_q <= STEP_W'(1);
    end else if (exec) begin
      if (uop.halt) halt_q <= 1'b1;
      step_q <= uop.last ? '0 : step_q + 1'b1;
    end
  end

  assign halted = halt_q;
  assign dbg_op = op_q;
  assign dbg_x  = x_q;

  AST_FETCH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> mem_addr == $past(mem_addr) + 1'b1); // R2
  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(mem_addr) && $stable(dbg_x) && $stable(dbg_op))); // R10
endmodule

// File: tb/sim_bytecore_top.sv
`timescale 1ns/100ps
module sim_bytecore_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] mem_addr;
  logic [7:0]  rd_data;
  logic        halted;
  logic [7:0]  dbg_op, dbg_x;
  logic [7:0]  rom [512];
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  assign rd_data = rom[mem_addr[8:0]];

  bytecore_top u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .rd_data(rd_data),
    .halted(halted), .dbg_op(dbg_op), .dbg_x(dbg_x)
  );

  // {x, t, sum, carry, sign}
  localparam logic [7:0] VEC [5][5] = '{
    '{8'd3,   8'd4,   8'd7,   8'd0, 8'd0},
    '{8'd100, 8'd50,  8'd150, 8'd0, 8'd1},
    '{8'd200, 8'd100, 8'd44,  8'd1, 8'd0},
    '{8'd255, 8'd1,   8'd0,   8'd1, 8'd0},
    '{8'd200, 8'd200, 8'd144, 8'd1, 8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 512; i++) rom[i] = 8'hFF;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    rom[a] = b;
  endtask

  task automatic run();
    int cnt;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    while (!halted && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    if (!halted) chk("R10 halt reached", 32'd0, 32'd1);
  endtask

  task automatic load_add_prog(input logic [7:0] x, input logic [7:0] t);
    wipe();
    put(0, 8'h01); put(1, t); put(2, 8'h02);
    put(3, 8'h01); put(4, x); put(5, 8'h03); put(6, 8'h04);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wipe();
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 addr", mem_addr, 0);
    chk("R1 x", dbg_x, 0);
    chk("R1 op", dbg_op, 0);
    chk("R1 halted", halted, 0);

    // table: add result, sign via jmi, carry via second add
    for (int v = 0; v < 5; v++) begin
      load_add_prog(VEC[v][0], VEC[v][1]);
      put(7, 8'h05); put(8, 8'h0A); put(9, 8'hFF); put(10, 8'hFF);
      run();
      chk("R6 sum", dbg_x, VEC[v][2]);
      chk("R8 sign via jmi", mem_addr, VEC[v][4] ? 24'h0B : 24'h0A);
      load_add_prog(VEC[v][0], VEC[v][1]);
      put(7, 8'h01); put(8, 8'h00); put(9, 8'h04); put(10, 8'hFF);
      run();
      chk("R6 carry", dbg_x, VEC[v][1] + VEC[v][3]);
    end

    // R7 clear carry after an add that carried
    load_add_prog(8'd100, 8'd200);
    put(7, 8'h03); put(8, 8'h01); put(9, 8'h00); put(10, 8'h04); put(11, 8'hFF);
    run();
    chk("R7 clc", dbg_x, 200);

    // R5 exchange, then R4 loads
    wipe();
    put(0, 8'h01); put(1, 8'h5A); put(2, 8'h02);
    put(3, 8'h01); put(4, 8'hC3); put(5, 8'h02); put(6, 8'hFF);
    run();
    chk("R5 x after swap", dbg_x, 8'h5A);
    put(6, 8'h01); put(7, 8'h00); put(8, 8'h03); put(9, 8'h04); put(10, 8'hFF);
    run();
    chk("R5 t after swap", dbg_x, 8'hC3);

    // R3 unknown opcode as nop, R4 operand skip
    wipe();
    put(0, 8'h77); put(1, 8'h01); put(2, 8'h05); put(3, 8'hFF);
    run();
    chk("R4 ldx", dbg_x, 5);
    chk("R3 unknown nop addr", mem_addr, 4);
    chk("R3 halt opcode", dbg_op, 8'hFF);

    // R9 jump keeps high address bits
    wipe();
    put(0, 8'h06); put(1, 8'hFE); put(254, 8'h00); put(255, 8'h00);
    put(256, 8'h06); put(257, 8'h10); put(272, 8'hFF); put(16, 8'h01);
    run();
    chk("R9 high bits kept", mem_addr, 24'h111);
    chk("R2 sequential past 0xFF", dbg_x, 0);

    // R11 Fibonacci
    wipe();
    put(0, 8'h00); put(1, 8'h01); put(2, 8'h01); put(3, 8'h02);
    put(4, 8'h01); put(5, 8'h00); put(6, 8'h03); put(7, 8'h04);
    put(8, 8'h05); put(9, 8'h0D); put(10, 8'h02); put(11, 8'h06);
    put(12, 8'h06); put(13, 8'hFF);
    run();
    chk("R11 fib x", dbg_x, 144);
    chk("R11 halt addr", mem_addr, 24'h0E);

    // R10 hold while halted
    repeat (20) @(negedge clk);
    chk("R10 halted", halted, 1);
    chk("R10 addr hold", mem_addr, 24'h0E);
    chk("R10 x hold", dbg_x, 144);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule